// File: doc/BRIEF.md
# Watchdog and Reset Supervisor

This block drives the active-low reset line of a host processor. The line is pulled low for three reasons: the block has just come out of its own reset (power-up), a low-supply indication from an external voltage comparator is present, or a programmable watchdog has run out because the host stopped restarting it. The output is an open-drain enable. When it is 1, the pad pulls the reset line low. When it is 0, the pad releases the line to its pull-up.

All timing is counted in ticks of a 32.768 kHz derived clock. The tick arrives as a one-cycle enable on the fast system clock. A reset caused by power-up or by low supply is stretched: the line releases a fixed 8192 ticks (nominally 250 ms) after the block's reset is released or after the low-supply indication clears. A watchdog expiry holds the line low for the same 8192 ticks. The host chooses one of three watchdog periods with a two-bit select, or it turns the watchdog off. Host bus activity produces a restart strobe, and the strobe reloads the watchdog.

Top module: `wdog_rst_supervisor`

## Requirements
- R1: After `rst_n` is released with `supply_low` at 0, `rst_pull_low` stays 1 and returns to 0 exactly `PULSE_TICKS` ticks later.
- R2: While `supply_low` is 1, `rst_pull_low` is 1 from the next clock edge onward. After `supply_low` returns to 0, the release delay of `PULSE_TICKS` ticks starts again from zero.
- R3: While the line is released and no restart strobe arrives, the watchdog pulls the line low once it has counted its full period of ticks. The period codes on `wd_sel` are: 2'b00 selects `PERIOD0_TICKS`, 2'b01 selects `PERIOD1_TICKS`, and 2'b10 selects `PERIOD2_TICKS`.
- R4: After a watchdog expiry, `rst_pull_low` stays 1 for exactly `PULSE_TICKS` ticks.
- R5: A `wd_kick` pulse while the line is released reloads the watchdog, so kicks that arrive more often than the period prevent any watchdog reset.
- R6: With `wd_sel` = 2'b11 the watchdog is disabled, and no watchdog reset occurs however long the line stays released.
- R7: A `wd_kick` that arrives while the line is pulled low is ignored. It neither shortens nor lengthens the reset pulse.
- R8: When a reset pulse ends, the watchdog starts again from its full period.
- R9: Counting advances only on cycles where `tick` is 1. With `tick` held at 0, no delay or period elapses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream (power-up event) |
| tick | input | 1 | One-cycle enable at the 32.768 kHz rate |
| supply_low | input | 1 | Synchronised low-supply indication from the comparator, active high |
| wd_kick | input | 1 | Watchdog restart strobe from host bus activity |
| wd_sel | input | 2 | Watchdog period select: 00, 01 or 10 picks a period, 11 disables the watchdog |
| rst_pull_low | output | 1 | Open-drain enable: 1 pulls the processor reset line low |

## Verification
The embedded assertions check the relations that hold on every cycle:
- a low-supply indication forces the line low on the next edge;
- a kick in the released state clears the watchdog count;
- a disabled watchdog never leaves the released state;
- the release-delay counter only ever advances by one tick at a time.

The exact lengths can only be shown by the bench's directed scenarios. Those lengths are the power-up and low-supply stretches, each of the three watchdog periods, the pulse length with a kick arriving in the middle, and the full reload after a pulse ends. The same holds for stalls with the tick held at 0, because they show up only as elapsed time.

// File: rtl/wdog_rst_pkg.sv
package wdog_rst_pkg;

  typedef enum logic [0:0] {
    SUP_HOLD = 1'b0,
    SUP_RUN  = 1'b1
  } sup_state_e;

  typedef enum logic [1:0] {
    WD_SEL_SHORT = 2'b00,
    WD_SEL_MID   = 2'b01,
    WD_SEL_LONG  = 2'b10,
    WD_SEL_OFF   = 2'b11
  } wd_sel_e;

endpackage

// File: rtl/wd_period_decode.sv
module wd_period_decode #(
  parameter int unsigned PERIOD0_TICKS = 8192,
  parameter int unsigned PERIOD1_TICKS = 24576,
  parameter int unsigned PERIOD2_TICKS = 49152,
  parameter int unsigned CW            = 16
) (
  input  logic [1:0]    sel,
  output logic [CW-1:0] limit,
  output logic          enable
);
  import wdog_rst_pkg::*;

  localparam logic [CW-1:0] LIM0 = CW'(PERIOD0_TICKS - 1);
  localparam logic [CW-1:0] LIM1 = CW'(PERIOD1_TICKS - 1);
  localparam logic [CW-1:0] LIM2 = CW'(PERIOD2_TICKS - 1);

  always_comb begin
    enable = 1'b1;
    unique case (wd_sel_e'(sel))
      WD_SEL_SHORT: limit = LIM0;
      WD_SEL_MID:   limit = LIM1;
      WD_SEL_LONG:  limit = LIM2;
      default: begin
        limit  = LIM0;
        enable = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/sup_hold_timer.sv
module sup_hold_timer #(
  parameter int unsigned PULSE_TICKS = 8192,
  parameter int unsigned CW          = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic cnt_en,
  output logic done
);
  localparam logic [CW-1:0] LAST = CW'(PULSE_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign done = cnt_en && !clr && (cnt_q >= LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr || done) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R1/R2: the release delay only ever steps by one tick or returns to zero
  assert_hold_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !clr && !done) |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_hold_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/wd_counter.sv
module wd_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          cnt_en,
  input  logic [CW-1:0] limit,
  output logic          expire
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign expire = cnt_en && !clr && (cnt_q >= limit);

  always_comb begin
    cnt_d = cnt_q;
    if (clr || expire) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R5: a reload request leaves the count at zero
  assert_kick_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

  // R9: without a count enable the count never moves unless cleared
  assert_count_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/wdog_rst_supervisor.sv
module wdog_rst_supervisor #(
  parameter int unsigned PULSE_TICKS   = 8192,
  parameter int unsigned PERIOD0_TICKS = 8192,
  parameter int unsigned PERIOD1_TICKS = 24576,
  parameter int unsigned PERIOD2_TICKS = 49152
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       supply_low,
  input  logic       wd_kick,
  input  logic [1:0] wd_sel,
  output logic       rst_pull_low
);
  import wdog_rst_pkg::*;

  localparam int unsigned MAX_P01 = (PERIOD0_TICKS > PERIOD1_TICKS) ? PERIOD0_TICKS : PERIOD1_TICKS;
  localparam int unsigned MAX_WD  = (MAX_P01 > PERIOD2_TICKS) ? MAX_P01 : PERIOD2_TICKS;
  localparam int unsigned MAX_ALL = (MAX_WD > PULSE_TICKS) ? MAX_WD : PULSE_TICKS;
  localparam int unsigned CW      = $clog2(MAX_ALL) + 1;

  sup_state_e    state_q;
  sup_state_e    state_d;
  logic [CW-1:0] wd_limit;
  logic          wd_enable;
  logic          hold_clr;
  logic          hold_en;
  logic          hold_done;
  logic          wd_clr;
  logic          wd_en;
  logic          wd_expire;

  wd_period_decode #(
    .PERIOD0_TICKS(PERIOD0_TICKS),
    .PERIOD1_TICKS(PERIOD1_TICKS),
    .PERIOD2_TICKS(PERIOD2_TICKS),
    .CW           (CW)
  ) u_decode (
    .sel   (wd_sel),
    .limit (wd_limit),
    .enable(wd_enable)
  );

  assign hold_clr = supply_low || (state_q == SUP_RUN);
  assign hold_en  = (state_q == SUP_HOLD) && tick && !supply_low;

  sup_hold_timer #(
    .PULSE_TICKS(PULSE_TICKS),
    .CW         (CW)
  ) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (hold_clr),
    .cnt_en(hold_en),
    .done  (hold_done)
  );

  // A kick only reaches the counter in the released state; in HOLD the
  // counter is held clear anyway, so the strobe has no effect there.
  assign wd_clr = (state_q == SUP_HOLD) || !wd_enable || wd_kick;
  assign wd_en  = (state_q == SUP_RUN) && tick && wd_enable && !supply_low;

  wd_counter #(
    .CW(CW)
  ) u_wd (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (wd_clr),
    .cnt_en(wd_en),
    .limit (wd_limit),
    .expire(wd_expire)
  );

  always_comb begin
    state_d = state_q;
    if (supply_low) begin
      state_d = SUP_HOLD;
    end else if ((state_q == SUP_HOLD) && hold_done) begin
      state_d = SUP_RUN;
    end else if ((state_q == SUP_RUN) && wd_expire) begin
      state_d = SUP_HOLD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SUP_HOLD;
    end else begin
      state_q <= state_d;
    end
  end

  assign rst_pull_low = (state_q == SUP_HOLD);

  // R2: a low supply pulls the line low on the following edge
  assert_lowv_forces_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |=> rst_pull_low);

  // R6: a disabled watchdog never ends the released state by itself
  assert_wd_off_no_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_pull_low && (wd_sel == 2'b11) && !supply_low) |=> !rst_pull_low);

  // R9: no tick, no change of the line unless the supply drops
  assert_no_tick_no_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !supply_low) |=> $stable(rst_pull_low));

endmodule

// File: tb/wdog_rst_supervisor_tb_top.sv
module wdog_rst_supervisor_tb_top;
  localparam int P  = 20;
  localparam int W0 = 16;
  localparam int W1 = 48;
  localparam int W2 = 96;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       supply_low;
  logic       wd_kick;
  logic [1:0] wd_sel;
  logic       rst_pull_low;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  wdog_rst_supervisor #(
    .PULSE_TICKS  (P),
    .PERIOD0_TICKS(W0),
    .PERIOD1_TICKS(W1),
    .PERIOD2_TICKS(W2)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .supply_low  (supply_low),
    .wd_kick     (wd_kick),
    .wd_sel      (wd_sel),
    .rst_pull_low(rst_pull_low)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Count rising edges until the line reaches target (sampled at negedge)
  task automatic edges_until(input logic target, input int lim, output int n);
    n = 0;
    while (n <= lim) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (rst_pull_low == target) break;
    end
  endtask

  // Line must keep value for ncyc cycles; returns 1 if it did
  task automatic stays(input logic val, input int ncyc, output int ok);
    ok = 1;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (rst_pull_low != val) ok = 0;
    end
  endtask

  task automatic t_powerup();
    int n;
    rst_n = 1'b0; tick = 1'b1; supply_low = 1'b0; wd_kick = 1'b0; wd_sel = 2'b00;
    repeat (3) @(negedge clk);
    check("R1 reset state", rst_pull_low, 1);
    rst_n = 1'b1;
    edges_until(1'b0, 4 * P, n);
    check("R1 power-up stretch", n, P);
  endtask

  task automatic t_expiry(input logic [1:0] sel, input int w, input string req);
    int n;
    wd_sel = sel;
    wd_kick = 1'b1;
    @(negedge clk);
    wd_kick = 1'b0;
    edges_until(1'b1, 4 * w, n);
    check(req, n, w);  // kick edge counted before this window: w edges remain
    edges_until(1'b0, 4 * P, n);
    check("R4 pulse length", n, P);
  endtask

  task automatic t_reload_after_pulse();
    int n;
    wd_sel = 2'b00;
    edges_until(1'b1, 4 * W0, n);
    check("R8 full period after pulse", n, W0);
    edges_until(1'b0, 4 * P, n);
    check("R4 pulse after reload", n, P);
  endtask

  task automatic t_kick_keeps();
    int ok;
    ok = 1;
    wd_sel = 2'b00;
    for (int k = 0; k < 8; k++) begin
      wd_kick = 1'b1;
      @(negedge clk);
      wd_kick = 1'b0;
      for (int i = 0; i < W0 / 2; i++) begin
        @(negedge clk);
        if (rst_pull_low) ok = 0;
      end
    end
    check("R5 regular kicks hold off reset", ok, 1);
  endtask

  task automatic t_disabled();
    int ok;
    wd_sel = 2'b11;
    stays(1'b0, 3 * W2, ok);
    check("R6 disabled watchdog", ok, 1);
  endtask

  task automatic t_low_supply();
    int n;
    supply_low = 1'b1;
    @(negedge clk);
    check("R2 low supply asserts next edge", rst_pull_low, 1);
    repeat (P / 2) @(negedge clk);
    supply_low = 1'b0;
    repeat (P / 2) @(negedge clk);
    supply_low = 1'b1;   // glitch restarts the delay
    @(negedge clk);
    supply_low = 1'b0;
    edges_until(1'b0, 4 * P, n);
    check("R2 release after supply recovers", n, P);
  endtask

  task automatic t_kick_in_hold();
    int n;
    wd_sel = 2'b00;
    edges_until(1'b1, 4 * W0, n);
    check("R3 expiry before kick-in-hold", n, W0);
    repeat (5) @(negedge clk);
    wd_kick = 1'b1;
    @(negedge clk);
    wd_kick = 1'b0;
    edges_until(1'b0, 4 * P, n);
    check("R7 kick ignored during pulse", n + 6, P);
  endtask

  task automatic t_tick_stall();
    int n;
    int ok;
    wd_sel = 2'b00;
    tick = 1'b0;
    wd_kick = 1'b1;
    @(negedge clk);
    wd_kick = 1'b0;
    stays(1'b0, 4 * W0, ok);
    check("R9 no ticks no expiry", ok, 1);
    tick = 1'b1;
    edges_until(1'b1, 4 * W0, n);
    check("R9 period counted in ticks", n, W0);
    edges_until(1'b0, 4 * P, n);
    check("R4 pulse after stall", n, P);
  endtask

  initial begin
    t_powerup();
    // after power-up release the watchdog (sel 00) is running from zero
    t_expiry(2'b00, W0, "R3 period code 00");
    t_expiry(2'b01, W1, "R3 period code 01");
    t_expiry(2'b10, W2, "R3 period code 10");
    t_reload_after_pulse();
    t_kick_keeps();
    t_disabled();
    t_low_supply();
    t_kick_in_hold();
    t_tick_stall();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule